// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is a byte-oriented SPI master that software drives through a 32-bit register bus. Bytes written to the transmit data register wait in a transmit queue. Each queued byte is shifted out on the serial data output. The byte clocked in at the same time lands in a receive queue, and software reads it back from the low eight bits of the receive data register. The serial clock mode, the bit order and an internal loopback path are selected in the control register. Chip selects are active low and are either driven directly from the slave-select register or asserted automatically while a byte is moving.

A typical driver clears the slave-select bit of its target device and writes one byte. It then polls the status register until transmit-empty is set, reads the received byte, and finally sets the slave-select bit again. A transaction-inhibit bit lets software fill the transmit queue before any clocking begins. The whole controller returns to its power-up state only when a fixed key value is written to the reset register. The interrupt registers hold their values and drive a single gated interrupt line.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset, control reads 0x180 (manual select and inhibit set), status reads 0x5, slave select reads all ones, the chip-select outputs are all high, SCLK is low and the interrupt is low.
- R2: A write of exactly 0x0000000A to offset 0x40 returns every register and both queues to the reset state two cycles later. Any other value written there changes nothing.
- R3: Control bits are loopback (0), enable (1), master (2), CPOL (3), CPHA (4), transmit clear (5), receive clear (6), manual select (7), inhibit (8) and LSB-first (9). Bits 5 and 6 always read back as 0, and the other eight read back as written.
- R4: Writing 1 to control bit 5 empties the transmit queue, and writing 1 to control bit 6 empties the receive queue.
- R5: With CPOL=0, CPHA=0 and MSB-first order, a byte written at 0x68 appears on MOSI starting with its most significant bit. The byte seen on MISO is pushed to the receive queue and is read at 0x6C in bits 7:0.
- R6: With LSB-first order (control bit 9), both the transmitted and the received byte start with bit 0.
- R7: SCLK idles at CPOL. With CPHA=0 both sides sample on the leading edge, and with CPHA=1 they sample on the trailing edge. All four modes round-trip a byte.
- R8: In loopback mode the received byte equals the transmitted byte, whatever MISO does.
- R9: No byte is clocked unless enable and master are both set and inhibit is clear. While clocking is held off, written bytes stay queued.
- R10: With manual select set, the chip-select outputs follow the slave-select register at 0x70 at all times. With manual select clear, the register value appears on the outputs only while a byte is in flight, and the outputs are all high otherwise.
- R11: Each queue holds 16 bytes. The occupancy registers (0x74 transmit, 0x78 receive) read the entry count minus one. Status bit 3 flags a full transmit queue and bit 1 a full receive queue. A byte pushed into a full queue is dropped.
- R12: Status bit 2 (transmit empty) is 1 only when the transmit queue is empty and no byte is in flight. Bit 0 flags an empty receive queue.
- R13: Interrupt status bit 2 at 0x20 sets when transmit empty rises, and writing 1 to a bit clears it. The interrupt output is high when bit 31 of 0x1C is set and some status bit is set whose enable bit at 0x28 is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a read of 0x6C pops the receive queue |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, valid in the same cycle |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | NUM_SS | Active-low chip selects |
| irq | output | 1 | Gated interrupt |

## Verification
The bench plays an SPI slave whose edge handling is written from the mode rules alone. It round-trips bytes in all four clock modes and in both bit orders. A design that sampled on the wrong edge would return data shifted by one bit, and one that swapped the bit order would return the byte reversed. Queue edges are driven hard. Seventeen bytes are written while inhibited, and the bench then expects a full flag, an occupancy of 15 and the loss of only the last byte. A design that wrapped its pointers would overwrite the oldest byte instead. The bench also writes a reset value close to the key and requires that nothing changes. It polls transmit empty and checks that the received byte is already waiting. A flag that looked only at the queue would report empty while the last byte was still in flight.

// File: rtl/spi_host_pkg.sv
// Shared constants for the SPI master controller: register offsets,
// control bit positions and interrupt bit positions.
package spi_host_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int CTRL_W   = 10;
    localparam int IRQ_W    = 8;

    localparam logic [ADDR_W-1:0] A_SRST  = 8'h40;
    localparam logic [ADDR_W-1:0] A_CTRL  = 8'h60;
    localparam logic [ADDR_W-1:0] A_STAT  = 8'h64;
    localparam logic [ADDR_W-1:0] A_TXD   = 8'h68;
    localparam logic [ADDR_W-1:0] A_RXD   = 8'h6C;
    localparam logic [ADDR_W-1:0] A_SSEL  = 8'h70;
    localparam logic [ADDR_W-1:0] A_TXOCC = 8'h74;
    localparam logic [ADDR_W-1:0] A_RXOCC = 8'h78;
    localparam logic [ADDR_W-1:0] A_GIE   = 8'h1C;
    localparam logic [ADDR_W-1:0] A_ISR   = 8'h20;
    localparam logic [ADDR_W-1:0] A_IER   = 8'h28;

    localparam logic [DATA_W-1:0] SRST_KEY = 32'h0000_000A;

    localparam int C_LOOP  = 0;
    localparam int C_EN    = 1;
    localparam int C_MST   = 2;
    localparam int C_CPOL  = 3;
    localparam int C_CPHA  = 4;
    localparam int C_TXCLR = 5;
    localparam int C_RXCLR = 6;
    localparam int C_MANSS = 7;
    localparam int C_INHIB = 8;
    localparam int C_LSB   = 9;

    localparam logic [CTRL_W-1:0] CTRL_KEEP = 10'h39F;
    localparam logic [CTRL_W-1:0] CTRL_RST  = 10'h180;

    localparam int IRQ_TXE = 2;

    typedef logic [7:0] spi_byte_t;
endpackage

// File: rtl/spi_fifo.sv
// Synchronous FIFO for the transmit and receive queues.
// Assumes DEPTH is a power of two. A push while full and a pop while
// empty are dropped. clr empties the queue in one cycle.
module spi_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic             do_push, do_pop;

    assign full    = (cnt == FULL_CNT);
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];
    assign count   = cnt;

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and count update, cleared by reset or clr.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R11: the count never passes the depth
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_CNT);

    // R11: a push into a full queue is dropped
    a_r11_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/spi_shift_engine.sv
// Serial shift engine: moves one byte per start pulse in any CPOL/CPHA
// mode and either bit order. SCLK half period is CLK_DIV system clocks.
// Assumes CLK_DIV >= 2 and that the configuration holds during a byte.
module spi_shift_engine #(
    parameter int CLK_DIV = 4,
    localparam int DIV_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_cpol,
    input  logic                   cfg_cpha,
    input  logic                   cfg_lsb,
    input  logic                   cfg_loop,
    input  logic                   start,
    input  spi_host_pkg::spi_byte_t tx_byte,
    output logic                   busy,
    output logic                   done,
    output spi_host_pkg::spi_byte_t rx_byte,
    output logic                   sclk,
    output logic                   mosi,
    input  logic                   miso
);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

    logic [DIV_W-1:0] div_cnt;
    logic [3:0]       edge_cnt;
    logic             phase;
    logic [7:0]       tx_sh, rx_sh, rx_next;
    logic             tick, sample_now, shift_now, in_bit;

    assign tick       = busy && (div_cnt == DIV_LAST);
    assign sample_now = tick && (edge_cnt[0] == cfg_cpha);
    assign shift_now  = tick && (edge_cnt[0] != cfg_cpha)
                        && !(cfg_cpha && edge_cnt == 4'd0);
    assign mosi       = cfg_lsb ? tx_sh[0] : tx_sh[7];
    assign in_bit     = cfg_loop ? mosi : miso;
    assign rx_next    = cfg_lsb ? {in_bit, rx_sh[7:1]} : {rx_sh[6:0], in_bit};
    assign done       = tick && (edge_cnt == 4'd15);
    assign rx_byte    = sample_now ? rx_next : rx_sh;
    assign sclk       = cfg_cpol ^ phase;

    // Sequencing: divider, edge counter and clock phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            div_cnt  <= '0;
            edge_cnt <= '0;
            phase    <= 1'b0;
        end else if (start && !busy) begin
            busy     <= 1'b1;
            div_cnt  <= '0;
            edge_cnt <= '0;
            phase    <= 1'b0;
        end else if (tick) begin
            div_cnt  <= '0;
            edge_cnt <= edge_cnt + 1'b1;
            phase    <= done ? 1'b0 : !phase;
            if (done) busy <= 1'b0;
        end else if (busy) begin
            div_cnt  <= div_cnt + 1'b1;
        end
    end

    // Data path: load, shift out and capture in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
            rx_sh <= '0;
        end else begin
            if (start && !busy) begin
                tx_sh <= tx_byte;
                rx_sh <= '0;
            end else begin
                if (shift_now) tx_sh <= cfg_lsb ? {1'b0, tx_sh[7:1]} : {tx_sh[6:0], 1'b0};
                if (sample_now) rx_sh <= rx_next;
            end
        end
    end

    // R7: MOSI holds its value across each sampling edge
    a_r7_mosi_stable_at_sample: assert property (@(posedge clk) disable iff (!rst_n)
        sample_now |-> $stable(mosi));
endmodule

// File: rtl/spi_host_ctrl.sv
// SPI master controller top: register bus decode, reset key, slave
// selects, interrupt registers and the two queues around the engine.
// Assumes single-cycle register accesses; reads are combinational and a
// read of the receive data offset pops the receive queue.
module spi_host_ctrl #(
    parameter int NUM_SS     = 4,
    parameter int FIFO_DEPTH = 16,
    parameter int CLK_DIV    = 4,
    localparam int OCC_W     = $clog2(FIFO_DEPTH),
    localparam int CNT_W     = OCC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_SS-1:0] spi_ss_n,
    output logic              irq
);
    import spi_host_pkg::*;

    logic                soft_rst_q, core_rst_n;
    logic [CTRL_W-1:0]   ctrl_q;
    logic [NUM_SS-1:0]   ssel_q;
    logic                gie_q;
    logic [IRQ_W-1:0]    ier_q, isr_q, isr_next;
    logic                txe_flag, txe_prev;
    logic                tx_push, tx_clr, rx_pop, rx_clr;
    logic                tx_full, tx_empty, rx_full, rx_empty;
    logic [CNT_W-1:0]    tx_cnt, rx_cnt;
    spi_byte_t           tx_dout, rx_dout, rx_byte;
    logic                start, busy, done, run_ok;

    assign core_rst_n = rst_n && !soft_rst_q;
    assign tx_push    = bus_wr && (bus_addr == A_TXD);
    assign tx_clr     = bus_wr && (bus_addr == A_CTRL) && bus_wdata[C_TXCLR];
    assign rx_clr     = bus_wr && (bus_addr == A_CTRL) && bus_wdata[C_RXCLR];
    assign rx_pop     = bus_rd && (bus_addr == A_RXD);
    assign run_ok     = ctrl_q[C_EN] && ctrl_q[C_MST] && !ctrl_q[C_INHIB];
    assign start      = run_ok && !tx_empty && !busy;
    assign txe_flag   = tx_empty && !busy;

    // Reset key detection: one-cycle pulse on an exact key write.
    always_ff @(posedge clk) begin
        if (!rst_n) soft_rst_q <= 1'b0;
        else        soft_rst_q <= bus_wr && (bus_addr == A_SRST) && (bus_wdata == SRST_KEY);
    end

    // Writable configuration registers.
    always_ff @(posedge clk) begin
        if (!core_rst_n) begin
            ctrl_q <= CTRL_RST;
            ssel_q <= '1;
            gie_q  <= 1'b0;
            ier_q  <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_CTRL:  ctrl_q <= bus_wdata[CTRL_W-1:0] & CTRL_KEEP;
                A_SSEL:  ssel_q <= bus_wdata[NUM_SS-1:0];
                A_GIE:   gie_q  <= bus_wdata[31];
                A_IER:   ier_q  <= bus_wdata[IRQ_W-1:0];
                default: ;
            endcase
        end
    end

    // Interrupt status next value: write-one-to-clear, event set wins.
    always_comb begin
        isr_next = isr_q;
        if (bus_wr && bus_addr == A_ISR) isr_next = isr_q & ~bus_wdata[IRQ_W-1:0];
        if (txe_flag && !txe_prev)       isr_next[IRQ_TXE] = 1'b1;
    end

    // Interrupt status and edge history registers.
    always_ff @(posedge clk) begin
        if (!core_rst_n) begin
            isr_q    <= '0;
            txe_prev <= 1'b1;
        end else begin
            isr_q    <= isr_next;
            txe_prev <= txe_flag;
        end
    end

    assign irq = gie_q && |(isr_q & ier_q);

    // Chip-select drive: manual follows register, automatic only in flight.
    always_comb begin
        if (ctrl_q[C_MANSS] || busy) spi_ss_n = ssel_q;
        else                         spi_ss_n = '1;
    end

    // Register read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata[CTRL_W-1:0] = ctrl_q;
            A_STAT:  bus_rdata[3:0] = {tx_full, txe_flag, rx_full, rx_empty};
            A_RXD:   bus_rdata[7:0] = rx_empty ? 8'h00 : rx_dout;
            A_SSEL:  bus_rdata[NUM_SS-1:0] = ssel_q;
            A_TXOCC: bus_rdata[OCC_W-1:0] = OCC_W'(tx_cnt - 1'b1);
            A_RXOCC: bus_rdata[OCC_W-1:0] = OCC_W'(rx_cnt - 1'b1);
            A_GIE:   bus_rdata[31] = gie_q;
            A_ISR:   bus_rdata[IRQ_W-1:0] = isr_q;
            A_IER:   bus_rdata[IRQ_W-1:0] = ier_q;
            default: bus_rdata = '0;
        endcase
    end

    spi_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(core_rst_n), .clr(tx_clr),
        .push(tx_push), .din(bus_wdata[7:0]), .pop(start),
        .dout(tx_dout), .full(tx_full), .empty(tx_empty), .count(tx_cnt)
    );

    spi_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(core_rst_n), .clr(rx_clr),
        .push(done), .din(rx_byte), .pop(rx_pop),
        .dout(rx_dout), .full(rx_full), .empty(rx_empty), .count(rx_cnt)
    );

    spi_shift_engine #(.CLK_DIV(CLK_DIV)) u_engine (
        .clk(clk), .rst_n(core_rst_n),
        .cfg_cpol(ctrl_q[C_CPOL]), .cfg_cpha(ctrl_q[C_CPHA]),
        .cfg_lsb(ctrl_q[C_LSB]), .cfg_loop(ctrl_q[C_LOOP]),
        .start(start), .tx_byte(tx_dout), .busy(busy), .done(done),
        .rx_byte(rx_byte), .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso)
    );

    // R2: the key pulse restores the configuration registers
    a_r2_key_restores: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_q |=> (ctrl_q == CTRL_RST && ssel_q == '1 && !gie_q));

    // R9: an idle engine stays idle while inhibit is set
    a_r9_inhibit_holds: assert property (@(posedge clk) disable iff (!core_rst_n)
        (ctrl_q[C_INHIB] && !busy) |=> !busy);

    // R4: a transmit clear write leaves the transmit queue empty
    a_r4_tx_clear_empties: assert property (@(posedge clk) disable iff (!core_rst_n)
        tx_clr |=> tx_empty);

    // R13: a rising transmit-empty sets its interrupt status bit
    a_r13_txe_event_sets: assert property (@(posedge clk) disable iff (!core_rst_n)
        (txe_flag && !txe_prev) |=> isr_q[IRQ_TXE]);
endmodule

// File: tb/spi_host_ctrl_tb.sv
// Self-checking bench: register bus driver, behavioural SPI slave,
// directed corner cases and seeded random mode/byte round trips.
module spi_host_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sclk, spi_mosi;
    logic        spi_miso = 1'b0;
    logic [3:0]  spi_ss_n;
    logic        irq;

    int total = 0;
    int bad   = 0;

    // slave model state
    bit        slv_en = 1'b0, slv_cpha = 1'b0, slv_lsb = 1'b0;
    int        slv_e = 0;
    logic [7:0] slv_byte = '0, slv_acc = '0, slv_got = '0;

    always #5 clk = ~clk;

    spi_host_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_ss_n(spi_ss_n), .irq(irq)
    );

    function automatic logic slv_bit(int k);
        return slv_lsb ? slv_byte[k] : slv_byte[7-k];
    endfunction

    function automatic logic [31:0] mk_ctrl(bit loop_, bit cpol, bit cpha, bit manss, bit inhib, bit lsb);
        return 32'h6 | (32'(loop_)) | (32'(cpol) << 3) | (32'(cpha) << 4)
             | (32'(manss) << 7) | (32'(inhib) << 8) | (32'(lsb) << 9);
    endfunction

    function automatic logic [31:0] mk_stat(bit rxe, bit rxf, bit txe, bit txf);
        return {28'h0, txf, txe, rxf, rxe};
    endfunction

    // Slave: samples MOSI and drives MISO per the mode rules.
    always @(spi_sclk) begin
        if (slv_en) begin
            if ((slv_e % 2) == int'(slv_cpha)) begin
                if (slv_lsb) slv_acc[slv_e/2] = spi_mosi;
                else         slv_acc[7 - slv_e/2] = spi_mosi;
                if (slv_e/2 == 7) slv_got = slv_acc;
            end else begin
                if (slv_cpha) spi_miso = slv_bit(slv_e/2);
                else          spi_miso = slv_bit(((slv_e + 1)/2) % 8);
            end
            slv_e = (slv_e + 1) % 16;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle(string req);
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            rd(8'h64, s);
            if (s[2]) return;
        end
        check(req, 32'h0, 32'h4);
    endtask

    task automatic arm(logic [7:0] sb, bit cpha, bit lsb);
        slv_en = 1'b0;
        slv_byte = sb; slv_cpha = cpha; slv_lsb = lsb;
        slv_e = 0; slv_acc = '0; slv_got = '0;
        if (!cpha) spi_miso = slv_bit(0);
        slv_en = 1'b1;
    endtask

    task automatic xfer(string req, bit cpol, bit cpha, bit lsb, logic [7:0] tb_b, logic [7:0] sb);
        logic [31:0] d;
        wr(8'h60, mk_ctrl(0, cpol, cpha, 1, 0, lsb));
        arm(sb, cpha, lsb);
        wr(8'h68, {24'h0, tb_b});
        wait_idle(req);
        rd(8'h6C, d);
        check(req, d, {24'h0, sb});
        check(req, {24'h0, slv_got}, {24'h0, tb_b});
        check(req, {31'h0, spi_sclk}, {31'h0, cpol});
        slv_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=0x0 expected=0x1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(8'h60, d); check("R1", d, 32'h180);
        rd(8'h64, d); check("R1", d, mk_stat(1, 0, 1, 0));
        rd(8'h70, d); check("R1", d, 32'hF);
        check("R1", {27'h0, spi_ss_n, spi_sclk}, {27'h0, 4'hF, 1'b0});
        check("R1", {31'h0, irq}, 32'h0);

        // R3: readback, clear bits read 0
        wr(8'h60, 32'h3FF); rd(8'h60, d); check("R3", d, 32'h39F);
        wr(8'h60, 32'h186); rd(8'h60, d); check("R3", d, 32'h186);

        // R5: mode 0 MSB first, directed
        xfer("R5", 0, 0, 0, 8'hA5, 8'h3C);
        xfer("R5", 0, 0, 0, 8'h01, 8'h80);
        // R6: LSB first, asymmetric patterns
        xfer("R6", 0, 0, 1, 8'h01, 8'hC8);
        // R7: remaining modes
        xfer("R7", 1, 0, 0, 8'h96, 8'h69);
        xfer("R7", 0, 1, 0, 8'h81, 8'h7E);
        xfer("R7", 1, 1, 1, 8'h0F, 8'hE1);

        // R13: transmit-empty event latched, gated by enables
        rd(8'h20, d); check("R13", d, 32'h4);
        check("R13", {31'h0, irq}, 32'h0);
        wr(8'h28, 32'h4); check("R13", {31'h0, irq}, 32'h0);
        wr(8'h1C, 32'h8000_0000); check("R13", {31'h0, irq}, 32'h1);
        wr(8'h20, 32'h0); rd(8'h20, d); check("R13", d, 32'h4);
        wr(8'h20, 32'h4); rd(8'h20, d); check("R13", d, 32'h0);
        check("R13", {31'h0, irq}, 32'h0);

        // R8: loopback ignores MISO
        slv_en = 1'b0; spi_miso = 1'b1;
        wr(8'h60, mk_ctrl(1, 0, 0, 1, 0, 0));
        wr(8'h68, 32'h3C); wait_idle("R8");
        rd(8'h6C, d); check("R8", d, 32'h3C);

        // R9: inhibit keeps bytes queued
        wr(8'h60, mk_ctrl(1, 0, 0, 1, 1, 0));
        for (int i = 0; i < 3; i++) wr(8'h68, 32'(i + 8'h10));
        repeat (200) @(negedge clk);
        rd(8'h74, d); check("R9", d, 32'h2);
        rd(8'h64, d); check("R9", d, mk_stat(1, 0, 0, 0));
        // R12: transmit empty only after last byte is received
        wr(8'h60, mk_ctrl(1, 0, 0, 1, 0, 0));
        wait_idle("R12");
        rd(8'h78, d); check("R12", d, 32'h2);
        for (int i = 0; i < 3; i++) begin
            rd(8'h6C, d); check("R9", d, 32'(i + 8'h10));
        end
        rd(8'h64, d); check("R12", d, mk_stat(1, 0, 1, 0));

        // R11: overflow of the transmit queue
        wr(8'h60, mk_ctrl(1, 0, 0, 1, 1, 0));
        for (int i = 0; i < 17; i++) wr(8'h68, 32'(i));
        rd(8'h64, d); check("R11", d, mk_stat(1, 0, 0, 1));
        rd(8'h74, d); check("R11", d, 32'hF);
        wr(8'h60, mk_ctrl(1, 0, 0, 1, 0, 0));
        wait_idle("R11");
        rd(8'h64, d); check("R11", d, mk_stat(0, 1, 1, 0));
        rd(8'h78, d); check("R11", d, 32'hF);
        wr(8'h68, 32'h55); wait_idle("R11");
        rd(8'h6C, d); check("R11", d, 32'h0);
        rd(8'h78, d); check("R11", d, 32'hE);
        // R4: receive clear, then transmit clear
        wr(8'h60, mk_ctrl(1, 0, 0, 1, 0, 0) | 32'h40);
        rd(8'h64, d); check("R4", d, mk_stat(1, 0, 1, 0));
        rd(8'h60, d); check("R4", d, mk_ctrl(1, 0, 0, 1, 0, 0));
        wr(8'h60, mk_ctrl(1, 0, 0, 1, 1, 0));
        wr(8'h68, 32'h11); wr(8'h68, 32'h22);
        rd(8'h64, d); check("R4", d, mk_stat(1, 0, 0, 0));
        wr(8'h60, mk_ctrl(1, 0, 0, 1, 1, 0) | 32'h20);
        rd(8'h64, d); check("R4", d, mk_stat(1, 0, 1, 0));
        wr(8'h60, mk_ctrl(1, 0, 0, 1, 0, 0));
        repeat (100) @(negedge clk);
        rd(8'h64, d); check("R4", d, mk_stat(1, 0, 1, 0));

        // R10: manual and automatic selects
        wr(8'h60, mk_ctrl(0, 0, 0, 1, 0, 0));
        wr(8'h70, 32'hA); check("R10", {28'h0, spi_ss_n}, 32'hA);
        wr(8'h70, 32'hE);
        wr(8'h60, mk_ctrl(0, 0, 0, 0, 0, 0));
        check("R10", {28'h0, spi_ss_n}, 32'hF);
        arm(8'h5A, 0, 0);
        wr(8'h68, 32'hC3);
        repeat (20) @(negedge clk);
        check("R10", {28'h0, spi_ss_n}, 32'hE);
        wait_idle("R10");
        check("R10", {28'h0, spi_ss_n}, 32'hF);
        rd(8'h6C, d); check("R10", d, 32'h5A);
        slv_en = 1'b0;

        // R5/R6/R7: seeded random round trips
        for (int n = 0; n < 20; n++) begin
            bit cp, ch, lb;
            logic [7:0] tb_b, sb;
            cp = 1'($urandom); ch = 1'($urandom); lb = 1'($urandom);
            tb_b = 8'($urandom); sb = 8'($urandom);
            if (lb)            xfer("R6", cp, ch, lb, tb_b, sb);
            else if (cp || ch) xfer("R7", cp, ch, lb, tb_b, sb);
            else               xfer("R5", cp, ch, lb, tb_b, sb);
        end

        // R2: non-key value ignored, key resets
        wr(8'h60, mk_ctrl(1, 1, 0, 1, 0, 1));
        wr(8'h70, 32'h3);
        wr(8'h28, 32'h4);
        wr(8'h40, 32'h0000_010A);
        wr(8'h40, 32'h0000_000B);
        repeat (2) @(negedge clk);
        rd(8'h60, d); check("R2", d, mk_ctrl(1, 1, 0, 1, 0, 1));
        rd(8'h70, d); check("R2", d, 32'h3);
        wr(8'h40, 32'h0000_000A);
        repeat (2) @(negedge clk);
        rd(8'h60, d); check("R2", d, 32'h180);
        rd(8'h70, d); check("R2", d, 32'hF);
        rd(8'h28, d); check("R2", d, 32'h0);
        rd(8'h64, d); check("R2", d, mk_stat(1, 0, 1, 0));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule